// File: doc/BRIEF.md
# PRG Window Bank Controller with Nibble-Loaded IRQ Counter

This block turns CPU register writes into four 8 KB program-memory bank numbers and one interrupt line. Two of the bank registers can be written. The other two reset to the last two banks and stay fixed. One bit of a command register chooses which of two slots, the 0x8000 slot or the 0xC000 slot, gets the writable register and which gets the fixed second-to-last bank. The bank numbers for the two fixed registers are cut down by a parameter mask. All four bank numbers are then ORed with a parameter offset, so several images can sit side by side in one large memory.

Writes are decoded from the address ANDed with 0xF003. A mirroring register ignores the data value 0xFF. The interrupt section has an 8-bit reload value that is written one nibble at a time, an 8-bit up-counter and an enable flag. It also holds a saved enable copy, which a later acknowledge write puts back into the enable flag. An external clock-enable, `tick_i`, advances the counter. When the counter passes 0xFF it reloads and raises `irq_o`.

Top module: `prg_bank_ctl`

## Requirements
- R1: After reset, the writable bank registers and the command and mirroring registers read 0. The two fixed registers hold 0xFE and 0xFF, and `irq_o` is low. With the default mask 0x1F and offset 0, the slots therefore show 0x00, 0x00, 0x1E and 0x1F.
- R2: When command bit 1 is 0, `bank_8000_o` is register 0 ORed with the offset, and `bank_c000_o` is (register 2 AND mask) ORed with the offset.
- R3: When command bit 1 is 1, those two sources swap: the 0x8000 slot shows the masked register 2 and the 0xC000 slot shows register 0, each ORed with the offset.
- R4: `bank_a000_o` is always register 1 ORed with the offset. `bank_e000_o` is always (register 3 AND mask) ORed with the offset.
- R5: A write lands on the register chosen by address AND 0xF003. Addresses 0x8000 to 0x8003 write register 0 and 0xA000 to 0xA003 write register 1. Address bits 11 to 2 are ignored, so 0x8FF0 writes register 0.
- R6: A write to 0x9000 or 0x9001 loads `mirror_o`, except when the data is 0xFF. A write of 0xFF leaves `mirror_o` unchanged.
- R7: A write to 0x9002 or 0x9003 loads the command register. Only its bit 1 changes the slot mapping.
- R8: A write to 0xF000 replaces the low nibble of the reload value, and a write to 0xF001 replaces the high nibble. Both clear `irq_o`.
- R9: A write to 0xF002 clears `irq_o` and loads the counter from the reload value. It sets the enable flag from data bit 1 and saves data bit 0. No counting happens in that cycle.
- R10: A write to 0xF003 clears `irq_o` and copies the saved bit into the enable flag.
- R11: In a cycle with `tick_i` high and the enable flag set, the counter increments. At 0xFF it instead reloads from the reload value and sets `irq_o`. `irq_o` then stays high until an acknowledge write. When the enable flag is clear, the counter holds. A wrap in the same cycle as an acknowledge leaves `irq_o` high.
- R12: With `wr_en_i` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe for the mapper range |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| tick_i | input | 1 | Count enable for the IRQ counter |
| bank_8000_o | output | 8 | Bank number for the 0x8000 slot |
| bank_a000_o | output | 8 | Bank number for the 0xA000 slot |
| bank_c000_o | output | 8 | Bank number for the 0xC000 slot |
| bank_e000_o | output | 8 | Bank number for the 0xE000 slot |
| mirror_o | output | 8 | Mirroring register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The slot mapping is checked with random register values under both settings of the swap bit. This separates a correct swap from a swap that is stuck, inverted or missing the mask. Random writes also use aliased addresses and the data value 0xFF, which shows whether decoding uses only address bits 15 to 12 and 1 to 0, and whether the mirroring filter works.

The interrupt path gets directed sequences:
- Reload values built from two nibbles near 0xFF make the wrap come after a known number of ticks. Any error in the nibble order or in the reload shows up as an interrupt in the wrong cycle.
- A load with the saved bit set but the enable bit clear, followed by a re-enable write, tests the saved-bit path.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  typedef struct packed {
    logic bank0;
    logic bank1;
    logic mirr;
    logic cmd;
    logic lat_lo;
    logic lat_hi;
    logic irq_ctl;
    logic irq_ack;
  } wr_sel_t;

  localparam int unsigned NUM_WIN = 4;

  // window index -> source register when swap bit is clear / set
  function automatic int unsigned win_src(input int unsigned win, input logic swap);
    case (win)
      0:       win_src = swap ? 2 : 0;
      2:       win_src = swap ? 0 : 2;
      default: win_src = win;
    endcase
  endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_bank_pkg::*;
(
  input  logic        wr_en_i,
  input  logic [15:0] wr_addr_i,
  output wr_sel_t     sel_o
);

  logic [3:0] page;
  logic [1:0] sub;

  assign page = wr_addr_i[15:12];
  assign sub  = wr_addr_i[1:0];

  always_comb begin
    sel_o = '0;
    if (wr_en_i) begin
      unique case (page)
        4'h8: sel_o.bank0 = 1'b1;
        4'hA: sel_o.bank1 = 1'b1;
        4'h9: begin
          sel_o.mirr = ~sub[1];
          sel_o.cmd  =  sub[1];
        end
        4'hF: begin
          sel_o.lat_lo  = (sub == 2'd0);
          sel_o.lat_hi  = (sub == 2'd1);
          sel_o.irq_ctl = (sub == 2'd2);
          sel_o.irq_ack = (sub == 2'd3);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    assert ($onehot0(sel_o)) else $error("a_r5_onehot_sel");
  end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int unsigned          BANK_W    = 8,
  parameter logic [BANK_W-1:0]    PRG_MASK  = 8'h1F,
  parameter logic [BANK_W-1:0]    OUTER_OFS = 8'h00
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  wr_sel_t                 sel_i,
  input  logic [7:0]              data_i,
  output logic [NUM_WIN-1:0][BANK_W-1:0] win_o,
  output logic [7:0]              mirror_o
);

  localparam logic [BANK_W-1:0] FIX_LAST = '1;
  localparam logic [BANK_W-1:0] FIX_PREV = FIX_LAST - BANK_W'(1);

  logic [NUM_WIN-1:0][BANK_W-1:0] regs;
  logic [7:0] cmd_q;
  logic       swap;

  assign swap = cmd_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs[0]  <= '0;
      regs[1]  <= '0;
      regs[2]  <= FIX_PREV;
      regs[3]  <= FIX_LAST;
      cmd_q    <= '0;
      mirror_o <= '0;
    end else begin
      if (sel_i.bank0) regs[0] <= BANK_W'(data_i);
      if (sel_i.bank1) regs[1] <= BANK_W'(data_i);
      if (sel_i.cmd)   cmd_q   <= data_i;
      if (sel_i.mirr && data_i != 8'hFF) mirror_o <= data_i;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [BANK_W-1:0] raw;
    logic [BANK_W-1:0] msk;
    always_comb begin
      raw = regs[win_src(w, 1'b0)];
      if (swap) raw = regs[win_src(w, 1'b1)];
    end
    // registers 2 and 3 carry the mask; they land on slot 2 or 0 depending on swap
    if (w == 1) begin : g_nomask
      assign msk = '1;
    end else if (w == 3) begin : g_fixmask
      assign msk = PRG_MASK;
    end else begin : g_swapmask
      assign msk = (win_src(w, 1'b0) == 2) ^ swap ? PRG_MASK : '1;
    end
    assign win_o[w] = (raw & msk) | OUTER_OFS;
  end

  a_r6_ff_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.mirr && data_i == 8'hFF) |=> $stable(mirror_o));
  a_r12_idle_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> ($stable(regs) && $stable(cmd_q) && $stable(mirror_o)));
  a_r4_last_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(win_o[3]));
  a_r3_swap_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.cmd && (data_i[1] != swap) && !sel_i.bank0) |=>
      (win_o[0] == $past(win_o[2]) && win_o[2] == $past(win_o[0])));

endmodule

// File: rtl/prg_irq_unit.sv
module prg_irq_unit
  import prg_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wr_sel_t    sel_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  output logic       irq_o
);

  localparam int unsigned NIB_W = CNT_W / 2;

  logic [CNT_W-1:0] latch_q, cnt_q;
  logic             en_q, saved_q;
  logic             step, wrap, ack;

  assign step = en_q && tick_i && !sel_i.irq_ctl;
  assign wrap = step && (cnt_q == '1);
  assign ack  = sel_i.lat_lo | sel_i.lat_hi | sel_i.irq_ctl | sel_i.irq_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      saved_q <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (sel_i.lat_lo) latch_q[NIB_W-1:0]     <= data_i[NIB_W-1:0];
      if (sel_i.lat_hi) latch_q[CNT_W-1:NIB_W] <= data_i[NIB_W-1:0];

      if (sel_i.irq_ctl)  cnt_q <= latch_q;
      else if (wrap)      cnt_q <= latch_q;
      else if (step)      cnt_q <= cnt_q + CNT_W'(1);

      if (sel_i.irq_ctl) begin
        en_q    <= data_i[1];
        saved_q <= data_i[0];
      end else if (sel_i.irq_ack) begin
        en_q    <= saved_q;
      end

      if (wrap)     irq_o <= 1'b1;
      else if (ack) irq_o <= 1'b0;
    end
  end

  a_r9_load_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.irq_ctl |=> (cnt_q == $past(latch_q) && !irq_o));
  a_r11_wrap_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i && cnt_q == '1 && !sel_i.irq_ctl) |=> (irq_o && cnt_q == $past(latch_q)));
  a_r11_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !sel_i.irq_ctl) |=> $stable(cnt_q));
  a_r10_reenable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.irq_ack |=> (en_q == $past(saved_q)));
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i.lat_lo || sel_i.lat_hi) && !(en_q && tick_i && cnt_q == '1)) |=> !irq_o);

endmodule

// File: rtl/prg_bank_ctl.sv
module prg_bank_ctl
  import prg_bank_pkg::*;
#(
  parameter int unsigned       BANK_W    = 8,
  parameter logic [BANK_W-1:0] PRG_MASK  = 8'h1F,
  parameter logic [BANK_W-1:0] OUTER_OFS = 8'h00,
  parameter int unsigned       CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              tick_i,
  output logic [BANK_W-1:0] bank_8000_o,
  output logic [BANK_W-1:0] bank_a000_o,
  output logic [BANK_W-1:0] bank_c000_o,
  output logic [BANK_W-1:0] bank_e000_o,
  output logic [7:0]        mirror_o,
  output logic              irq_o
);

  wr_sel_t sel;
  logic [NUM_WIN-1:0][BANK_W-1:0] win;

  prg_wr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .sel_o     (sel)
  );

  prg_bank_regs #(
    .BANK_W    (BANK_W),
    .PRG_MASK  (PRG_MASK),
    .OUTER_OFS (OUTER_OFS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .data_i   (wr_data_i),
    .win_o    (win),
    .mirror_o (mirror_o)
  );

  prg_irq_unit #(
    .CNT_W (CNT_W)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .data_i (wr_data_i),
    .tick_i (tick_i),
    .irq_o  (irq_o)
  );

  assign bank_8000_o = win[0];
  assign bank_a000_o = win[1];
  assign bank_c000_o = win[2];
  assign bank_e000_o = win[3];

endmodule

// File: tb/sim_prg_bank_ctl.sv
`timescale 1ns/1ps
module sim_prg_bank_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        tick = 1'b0;
  logic [7:0]  b8, ba, bc, be, mir;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prg_bank_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .tick_i(tick), .bank_8000_o(b8), .bank_a000_o(ba), .bank_c000_o(bc),
    .bank_e000_o(be), .mirror_o(mir), .irq_o(irq)
  );

  localparam logic [7:0] MASK = 8'h1F;
  localparam logic [7:0] OFS  = 8'h00;

  // reference state
  logic [7:0] m_r0, m_r1, m_cmd, m_mir, m_lat, m_cnt;
  logic       m_en, m_sav, m_irq;

  function automatic logic [7:0] exp_slot(input int s);
    logic [7:0] fixed2, fixed3;
    fixed2 = 8'hFE & MASK;
    fixed3 = 8'hFF & MASK;
    case (s)
      0: exp_slot = (m_cmd[1] ? fixed2 : m_r0) | OFS;
      1: exp_slot = m_r1 | OFS;
      2: exp_slot = (m_cmd[1] ? m_r0 : fixed2) | OFS;
      default: exp_slot = fixed3 | OFS;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_r0 = 0; m_r1 = 0; m_cmd = 0; m_mir = 0; m_lat = 0; m_cnt = 0;
    m_en = 0; m_sav = 0; m_irq = 0;
  endtask

  task automatic model_step(input logic w, input logic [15:0] a, input logic [7:0] d, input logic t);
    logic [15:0] s;
    logic ctl, ack, stp, wrp;
    logic [7:0] old_lat;
    s = a & 16'hF003;
    ctl = w && s == 16'hF002;
    ack = w && (s == 16'hF000 || s == 16'hF001 || s == 16'hF002 || s == 16'hF003);
    stp = m_en && t && !ctl;
    wrp = stp && m_cnt == 8'hFF;
    old_lat = m_lat;
    if (ctl) m_cnt = old_lat;
    else if (wrp) m_cnt = old_lat;
    else if (stp) m_cnt = m_cnt + 8'd1;
    if (wrp) m_irq = 1; else if (ack) m_irq = 0;
    if (w) begin
      case (s)
        16'h8000, 16'h8001, 16'h8002, 16'h8003: m_r0 = d;
        16'hA000, 16'hA001, 16'hA002, 16'hA003: m_r1 = d;
        16'h9000, 16'h9001: if (d != 8'hFF) m_mir = d;
        16'h9002, 16'h9003: m_cmd = d;
        16'hF000: m_lat[3:0] = d[3:0];
        16'hF001: m_lat[7:4] = d[3:0];
        16'hF002: begin m_en = d[1]; m_sav = d[0]; end
        16'hF003: m_en = m_sav;
        default: ;
      endcase
    end
  endtask

  task automatic check_all(input string tag);
    chk(m_cmd[1] ? "R3" : "R2", {tag, " slot8000"}, b8, exp_slot(0));
    chk("R4", {tag, " slotA000"}, ba, exp_slot(1));
    chk(m_cmd[1] ? "R3" : "R2", {tag, " slotC000"}, bc, exp_slot(2));
    chk("R4", {tag, " slotE000"}, be, exp_slot(3));
    chk("R6", {tag, " mirror"}, mir, m_mir);
    chk("R11", {tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  // one cycle: drive at negedge, sample 1 ns after posedge
  task automatic cyc(input logic w, input logic [15:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    we = w; addr = a; data = d; tick = t;
    @(posedge clk);
    model_step(w, a, d, t);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] pool [0:13];
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "reset 8000", b8, 8'h00);
    chk("R1", "reset A000", ba, 8'h00);
    chk("R1", "reset C000", bc, 8'h1E);
    chk("R1", "reset E000", be, 8'h1F);
    chk("R1", "reset irq", {7'd0, irq}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    check_all("post-reset");

    // R5: aliased address
    wr(16'h8FF0, 8'h05);
    chk("R5", "alias 8FF0 -> reg0", b8, 8'h05);
    wr(16'hAFFE, 8'h09);
    chk("R5", "alias AFFE -> reg1", ba, 8'h09);
    wr(16'h8FF4 | 16'h0002, 8'h06);
    chk("R5", "alias 8FF6 -> reg0", b8, 8'h06);

    // R7: swap via command register
    wr(16'h9003, 8'h02);
    chk("R7", "swap 8000", b8, 8'h1E);
    chk("R3", "swap C000", bc, 8'h06);
    wr(16'h9002, 8'hFD);
    chk("R7", "swap off 8000", b8, 8'h06);
    chk("R2", "swap off C000", bc, 8'h1E);

    // R6: mirror and the 0xFF filter
    wr(16'h9000, 8'h01);
    chk("R6", "mirror load", mir, 8'h01);
    wr(16'h9001, 8'hFF);
    chk("R6", "mirror FF ignored", mir, 8'h01);

    // R12: strobe low ignores bus
    cyc(0, 16'h8000, 8'h33, 0);
    chk("R12", "no write 8000", b8, 8'h06);
    cyc(0, 16'h9000, 8'h22, 0);
    chk("R12", "no write mirror", mir, 8'h01);

    // R8 + R9 + R11: latch 0xFE from nibbles, load enabled
    wr(16'hF000, 8'hAE);
    wr(16'hF001, 8'h5F);
    wr(16'hF002, 8'h02);
    cyc(0, 0, 0, 1);
    chk("R11", "no irq at FF", {7'd0, irq}, 8'd0);
    cyc(0, 0, 0, 1);
    chk("R11", "irq on wrap", {7'd0, irq}, 8'd1);
    cyc(0, 0, 0, 0);
    chk("R11", "irq held", {7'd0, irq}, 8'd1);
    wr(16'hF003, 8'h00);
    chk("R10", "ack clears", {7'd0, irq}, 8'd0);
    // saved bit was 0 -> disabled
    repeat (4) cyc(0, 0, 0, 1);
    chk("R10", "disabled by ack copy", {7'd0, irq}, 8'd0);

    // R9/R10: saved enable restored
    wr(16'hF002, 8'h01);
    repeat (3) cyc(0, 0, 0, 1);
    chk("R9", "enable from bit1 clear", {7'd0, irq}, 8'd0);
    wr(16'hF003, 8'h00);
    cyc(0, 0, 0, 1);
    chk("R10", "re-enabled count no irq yet", {7'd0, irq}, 8'd0);
    cyc(0, 0, 0, 1);
    chk("R10", "re-enabled wraps", {7'd0, irq}, 8'd1);
    // R8: nibble write clears pending irq
    wr(16'hF000, 8'h0E);
    chk("R8", "latch write acks", {7'd0, irq}, 8'd0);
    check_all("directed");

    // random phase
    pool[0] = 16'h8000; pool[1] = 16'h8003; pool[2] = 16'hA001; pool[3] = 16'hA002;
    pool[4] = 16'h9000; pool[5] = 16'h9001; pool[6] = 16'h9002; pool[7] = 16'h9003;
    pool[8] = 16'hF000; pool[9] = 16'hF001; pool[10] = 16'hF002; pool[11] = 16'hF003;
    pool[12] = 16'hC000; pool[13] = 16'h6000;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      logic w, t;
      w = ($urandom % 4) == 0;
      a = pool[$urandom % 14] | (16'($urandom) & 16'h0FFC);
      d = 8'($urandom);
      if (($urandom % 8) == 0) d = 8'hFF;
      if ((a & 16'hF003) == 16'hF001) d = d | 8'h0F;
      if ((a & 16'hF003) == 16'hF002) d = d | 8'h02;
      t = ($urandom % 2) == 0;
      cyc(w, a, d, t);
      check_all("random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule